// File: doc/BRIEF.md
# Request-to-Send and Half-Duplex Direction Control

This block drives the active-low request-to-send line of one serial channel and decides whether the transmitter may start a new character. It has two ways of driving the line. In the automatic way, the line follows receive-FIFO fullness, transmitter activity, or both. In the manual way, used when the line steers the direction of a shared half-duplex bus driver, firmware asserts and negates it with commands. A clear-to-send input, after resynchronisation, can hold off the start of each new character.

The block also feeds a multipurpose output pin. A three-bit selector chooses what that pin carries: the request-to-send level or an active-low receive-FIFO-full flag. The block carries no data stream, so every pin is a plain level or a single-cycle strobe with no handshake. A command strobe is taken in the cycle it is high and is never back-pressured.

Top module: `rts_flow_ctrl`

## Requirements
- R1: After reset `rts_n` is 1 (negated), `rx_enable` is 1, and `tx_permit` is 0 while `tx_wait_cts_en` is 1.
- R2: Manual mode is in force when `rx_auto_rts_en` and `tx_auto_rts_en` are both 0. In manual mode, a strobe on `cmd_valid` with `cmd_code` 4'h8 drives `rts_n` to 0 one clock edge later and holds `rx_enable` at 0 while `rts_n` is 0.
- R3: In manual mode, command code 4'h9 given while `tx_empty` is 1 drives `rts_n` to 1 and `rx_enable` to 1 one edge later.
- R4: In manual mode, command 4'h9 given while `tx_empty` is 0 leaves `rts_n` at 0 until `tx_empty` is 1. `rts_n` then rises one edge after the first cycle in which `tx_empty` is 1.
- R5: In manual mode, a command code other than 4'h8 or 4'h9 has no effect on `rts_n`. Changes on `rx_fifo_full`, `tx_load` and `tx_empty` also have no effect, apart from completing a pending negate as R4 describes.
- R6: With only `rx_auto_rts_en` set, `rts_n` becomes 1 one edge after `rx_fifo_full` is 1, and becomes 0 one edge after `rx_fifo_full` drops to 0.
- R7: With only `tx_auto_rts_en` set, `rts_n` becomes 0 one edge after a `tx_load` pulse. It stays 0 while `tx_empty` is 0, and becomes 1 one edge after `tx_empty` is 1 with no `tx_load` in the same cycle.
- R8: With both automatic bits set, `rts_n` is 0 only while a transmission is active and the receive FIFO is not full.
- R9: With `tx_wait_cts_en` set, `tx_permit` equals the inverse of `cts_n` as sampled two clock edges earlier. With `tx_wait_cts_en` clear, `tx_permit` is 1.
- R10: `pin_sel` 3'b000 puts `rts_n` on `mpo_n`. `pin_sel` 3'b111 puts the inverse of `rx_fifo_full` on `mpo_n`. Every other code holds `mpo_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_auto_rts_en | input | 1 | Automatic receive-side RTS enable |
| tx_auto_rts_en | input | 1 | Automatic transmit-side RTS enable |
| tx_wait_cts_en | input | 1 | Transmit start waits for CTS |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code (8 assert, 9 negate) |
| rx_fifo_full | input | 1 | Receive FIFO full |
| tx_load | input | 1 | Character loaded into transmitter |
| tx_empty | input | 1 | Transmitter empty |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| pin_sel | input | 3 | Multipurpose pin function select |
| rts_n | output | 1 | Request-to-send, active low |
| mpo_n | output | 1 | Multipurpose output pin |
| tx_permit | output | 1 | Transmitter may start a character |
| rx_enable | output | 1 | Receiver enable for half-duplex turnaround |

## Verification
The checker tests on every cycle the properties that follow from one cycle's inputs. It checks that a manual assert takes effect on the next edge, that no negate lands while the transmitter is busy, that a full FIFO drops the automatic request, that a load raises the transmit request, and that the permit matches CTS from two edges earlier. It also checks that the receiver enable mirrors the manual line and that the pin selector routes correctly. Only the bench's scenarios show the behaviours that span several events. These are a delayed negate that completes once the transmitter drains, commands being ignored, the AND of both automatic sources across a FIFO-full episode, and the reset levels.

// File: rtl/rtsfc_pkg.sv
package rtsfc_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_RTS_ON  = 4'h8;
  localparam logic [CMD_W-1:0] CMD_RTS_OFF = 4'h9;

  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    PIN_RTS  = 3'b000,
    PIN_FULL = 3'b111
  } pin_fn_e;
endpackage

// File: rtl/rtsfc_sync.sv
module rtsfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtsfc_level.sv
module rtsfc_level
  import rtsfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_auto_rts_en,
  input  logic             tx_auto_rts_en,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             rx_fifo_full,
  input  logic             tx_load,
  input  logic             tx_empty,
  output logic             rts_n,
  output logic             rx_enable
);
  logic manual;
  logic cmd_on, cmd_off;
  logic man_on_q, off_pend_q;
  logic tx_act_q, auto_on_q;
  logic tx_req, rx_req;

  assign manual  = !rx_auto_rts_en && !tx_auto_rts_en;
  assign cmd_on  = cmd_valid && (cmd_code == CMD_RTS_ON);
  assign cmd_off = cmd_valid && (cmd_code == CMD_RTS_OFF);

  // Commanded level; a negate waits for the transmitter to drain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_on_q   <= 1'b0;
      off_pend_q <= 1'b0;
    end else if (cmd_on) begin
      man_on_q   <= 1'b1;
      off_pend_q <= 1'b0;
    end else if (cmd_off) begin
      if (tx_empty) begin
        man_on_q   <= 1'b0;
        off_pend_q <= 1'b0;
      end else begin
        off_pend_q <= 1'b1;
      end
    end else if (off_pend_q && tx_empty) begin
      man_on_q   <= 1'b0;
      off_pend_q <= 1'b0;
    end
  end

  // Transmit activity: set on load, cleared once the transmitter is empty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_act_q <= 1'b0;
    else if (tx_load)  tx_act_q <= 1'b1;
    else if (tx_empty) tx_act_q <= 1'b0;
  end

  assign tx_req = !tx_auto_rts_en || tx_load || (tx_act_q && !tx_empty);
  assign rx_req = !rx_auto_rts_en || !rx_fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) auto_on_q <= 1'b0;
    else        auto_on_q <= tx_req && rx_req;
  end

  assign rts_n     = manual ? !man_on_q : !auto_on_q;
  assign rx_enable = !(manual && man_on_q);
endmodule

// File: rtl/rtsfc_pin_mux.sv
module rtsfc_pin_mux
  import rtsfc_pkg::*;
(
  input  logic [SEL_W-1:0] pin_sel,
  input  logic             rts_n,
  input  logic             rx_fifo_full,
  output logic             mpo_n
);
  always_comb begin
    case (pin_sel)
      PIN_RTS:  mpo_n = rts_n;
      PIN_FULL: mpo_n = !rx_fifo_full;
      default:  mpo_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
  import rtsfc_pkg::*;
#(
  parameter int CTS_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_auto_rts_en,
  input  logic             tx_auto_rts_en,
  input  logic             tx_wait_cts_en,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             rx_fifo_full,
  input  logic             tx_load,
  input  logic             tx_empty,
  input  logic             cts_n,
  input  logic [SEL_W-1:0] pin_sel,
  output logic             rts_n,
  output logic             mpo_n,
  output logic             tx_permit,
  output logic             rx_enable
);
  logic cts_seen;

  rtsfc_sync #(.STAGES(CTS_STAGES)) u_cts_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (!cts_n),
    .q     (cts_seen)
  );

  assign tx_permit = !tx_wait_cts_en || cts_seen;

  rtsfc_level u_level (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_auto_rts_en (rx_auto_rts_en),
    .tx_auto_rts_en (tx_auto_rts_en),
    .cmd_valid      (cmd_valid),
    .cmd_code       (cmd_code),
    .rx_fifo_full   (rx_fifo_full),
    .tx_load        (tx_load),
    .tx_empty       (tx_empty),
    .rts_n          (rts_n),
    .rx_enable      (rx_enable)
  );

  rtsfc_pin_mux u_pin (
    .pin_sel      (pin_sel),
    .rts_n        (rts_n),
    .rx_fifo_full (rx_fifo_full),
    .mpo_n        (mpo_n)
  );
endmodule

// File: rtl/rts_flow_ctrl_chk.sv
module rts_flow_ctrl_chk
  import rtsfc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rx_auto_rts_en,
  input logic             tx_auto_rts_en,
  input logic             tx_wait_cts_en,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_code,
  input logic             rx_fifo_full,
  input logic             tx_load,
  input logic             tx_empty,
  input logic             cts_n,
  input logic [SEL_W-1:0] pin_sel,
  input logic             rts_n,
  input logic             mpo_n,
  input logic             tx_permit,
  input logic             rx_enable
);
  logic man;
  assign man = !rx_auto_rts_en && !tx_auto_rts_en;

  assert_manual_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (man && cmd_valid && cmd_code == CMD_RTS_ON) |=>
      (rx_auto_rts_en || tx_auto_rts_en || !rts_n));

  assert_no_early_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (man && !rts_n && !tx_empty) |=>
      (rx_auto_rts_en || tx_auto_rts_en || !rts_n));

  assert_rx_follows_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    man |-> (rx_enable == rts_n));

  assert_full_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_auto_rts_en && !tx_auto_rts_en && rx_fifo_full) |=>
      (!rx_auto_rts_en || tx_auto_rts_en || rts_n));

  assert_load_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_auto_rts_en && !rx_auto_rts_en && tx_load) |=>
      (!tx_auto_rts_en || rx_auto_rts_en || !rts_n));

  assert_cts_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wait_cts_en && tx_permit) |-> !$past(cts_n, 2));

  assert_pin_rts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == PIN_RTS) |-> (mpo_n == rts_n));

  assert_pin_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel != PIN_RTS && pin_sel != PIN_FULL) |-> mpo_n);
endmodule

bind rts_flow_ctrl rts_flow_ctrl_chk u_chk (.*);

// File: tb/rts_flow_ctrl_bench.sv
module rts_flow_ctrl_bench;
  import rtsfc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_auto_rts_en = 1'b0, tx_auto_rts_en = 1'b0, tx_wait_cts_en = 1'b1;
  logic cmd_valid = 1'b0;
  logic [CMD_W-1:0] cmd_code = '0;
  logic rx_fifo_full = 1'b0, tx_load = 1'b0, tx_empty = 1'b1, cts_n = 1'b1;
  logic [SEL_W-1:0] pin_sel = 3'b000;
  logic rts_n, mpo_n, tx_permit, rx_enable;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rts_flow_ctrl u_rts_flow_ctrl (.*);

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [CMD_W-1:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    step(1);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rts_n", rts_n, 1'b1);
    chk("R1 rx_enable", rx_enable, 1'b1);
    chk("R1 tx_permit", tx_permit, 1'b0);
  endtask

  task automatic t_manual;
    send_cmd(CMD_RTS_ON);
    chk("R2 rts_n on", rts_n, 1'b0);
    chk("R2 rx_enable off", rx_enable, 1'b0);
    chk("R10 mpo shows rts", mpo_n, 1'b0);
    send_cmd(CMD_RTS_OFF);
    chk("R3 rts_n off", rts_n, 1'b1);
    chk("R3 rx_enable on", rx_enable, 1'b1);
  endtask

  task automatic t_turnaround;
    send_cmd(CMD_RTS_ON);
    tx_load = 1'b1; tx_empty = 1'b0;
    step(1);
    tx_load = 1'b0;
    send_cmd(CMD_RTS_OFF);
    chk("R4 held while busy", rts_n, 1'b0);
    step(3);
    chk("R4 still held", rts_n, 1'b0);
    tx_empty = 1'b1;
    step(1);
    chk("R4 released on empty", rts_n, 1'b1);
    chk("R4 rx back on", rx_enable, 1'b1);
  endtask

  task automatic t_ignored;
    send_cmd(4'h3);
    chk("R5 other cmd", rts_n, 1'b1);
    send_cmd(CMD_RTS_ON);
    send_cmd(4'hA);
    chk("R5 other cmd on", rts_n, 1'b0);
    rx_fifo_full = 1'b1; tx_empty = 1'b0; tx_load = 1'b1;
    step(1);
    tx_load = 1'b0;
    step(1);
    tx_empty = 1'b1;
    step(1);
    chk("R5 fifo/tx ignored", rts_n, 1'b0);
    rx_fifo_full = 1'b0;
    send_cmd(CMD_RTS_OFF);
    chk("R5 cleanup", rts_n, 1'b1);
  endtask

  task automatic t_rx_auto;
    rx_auto_rts_en = 1'b1;
    step(1);
    chk("R6 not full on", rts_n, 1'b0);
    rx_fifo_full = 1'b1;
    step(1);
    chk("R6 full off", rts_n, 1'b1);
    rx_fifo_full = 1'b0;
    step(1);
    chk("R6 drop reasserts", rts_n, 1'b0);
    rx_auto_rts_en = 1'b0;
  endtask

  task automatic t_tx_auto;
    tx_auto_rts_en = 1'b1;
    step(1);
    chk("R7 idle off", rts_n, 1'b1);
    tx_load = 1'b1; tx_empty = 1'b0;
    step(1);
    tx_load = 1'b0;
    chk("R7 load on", rts_n, 1'b0);
    step(4);
    chk("R7 busy on", rts_n, 1'b0);
    tx_empty = 1'b1;
    step(1);
    chk("R7 empty off", rts_n, 1'b1);
    tx_auto_rts_en = 1'b0;
  endtask

  task automatic t_both;
    rx_auto_rts_en = 1'b1; tx_auto_rts_en = 1'b1;
    step(1);
    chk("R8 idle off", rts_n, 1'b1);
    tx_load = 1'b1; tx_empty = 1'b0;
    step(1);
    tx_load = 1'b0;
    chk("R8 active on", rts_n, 1'b0);
    rx_fifo_full = 1'b1;
    step(1);
    chk("R8 full off", rts_n, 1'b1);
    rx_fifo_full = 1'b0;
    step(1);
    chk("R8 not full on", rts_n, 1'b0);
    tx_empty = 1'b1;
    step(1);
    chk("R8 empty off", rts_n, 1'b1);
    rx_auto_rts_en = 1'b0; tx_auto_rts_en = 1'b0;
    step(1);
  endtask

  task automatic t_cts;
    tx_wait_cts_en = 1'b1;
    chk("R9 no cts", tx_permit, 1'b0);
    cts_n = 1'b0;
    step(1);
    chk("R9 one edge", tx_permit, 1'b0);
    step(1);
    chk("R9 two edges", tx_permit, 1'b1);
    cts_n = 1'b1;
    step(2);
    chk("R9 drop", tx_permit, 1'b0);
    tx_wait_cts_en = 1'b0;
    #1;
    chk("R9 disabled", tx_permit, 1'b1);
    tx_wait_cts_en = 1'b1;
  endtask

  task automatic t_pin;
    pin_sel = 3'b111; rx_fifo_full = 1'b1;
    #1 chk("R10 full shown", mpo_n, 1'b0);
    rx_fifo_full = 1'b0;
    #1 chk("R10 not full", mpo_n, 1'b1);
    pin_sel = 3'b010; rx_fifo_full = 1'b1;
    send_cmd(CMD_RTS_ON);
    chk("R10 other code idle", mpo_n, 1'b1);
    pin_sel = 3'b000;
    #1 chk("R10 rts shown", mpo_n, 1'b0);
    rx_fifo_full = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(2);
    t_reset;
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_manual;
    t_turnaround;
    t_ignored;
    t_rx_auto;
    t_tx_auto;
    t_both;
    t_cts;
    t_pin;
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule